// File: doc/BRIEF.md
# IDE Bus-Master Register Window

This block decodes a small I/O window that holds the bus-master DMA control registers for a pair of IDE channels. Each channel owns an eight-byte slice. The low four bytes are byte-wide registers: a command byte, a view of the mode register that both channels share, a status byte and a UDMA timing byte. The high four bytes hold the 32-bit base address of that channel's descriptor table. Host accesses arrive as one strobe per cycle. Each strobe carries an address, a size code, write data and a direction. A read returns its data one cycle later.

The block does not store the shared mode register. It reads that register through an input and updates it through a write-enable and data pair. Only the two interrupt-block bits are allowed to change. The write-enable strobe also serves as the request to the interrupt aggregator to resync its mirrors and recompute its output. Toward the DMA engine, the block gives each channel start and stop pulses, a direction level and the descriptor base. The engine in turn drives an activity level and set pulses for the error and interrupt flags.

Top module: `ide_bm_window`

## Requirements
- R1: Channel c decodes window offsets 8c to 8c+7. Inside a slice, offset 0 is the command byte, 1 the shared mode view, 2 the status byte and 3 the timing byte. Offsets 4 to 7 are the descriptor base, least significant byte at offset 4.
- R2: A non-byte access to slice offsets 0 to 3 has no effect when it is a write. When it is a read it returns ones across the access width. Size code 0 is byte, 1 is half-word (read 0x0000FFFF), 2 is word and 3 is reserved (both read 0xFFFFFFFF).
- R3: A byte write to slice offset 1 pulses mode_we in the same cycle. mode_wr_data copies mode_rd with bits 5:4 replaced from the written data. A byte read of offset 1 in either slice returns mode_rd.
- R4: Status bit 0 shows the channel's engine activity level, sampled one cycle earlier, and writes do not touch it. Bits 6:5 load from a status write. Writing 1 to bit 1 or bit 2 clears that bit. Bits 7, 4 and 3 read as zero.
- R5: An engine error or interrupt set pulse sets status bit 1 or bit 2, even when a clearing write lands in the same cycle.
- R6: The command byte keeps only bit 0 (start) and bit 3 (direction), and the other bits read as zero. The direction output equals the stored bit 3.
- R7: A command write that moves bit 0 from 0 to 1 gives a one-cycle start pulse in the next cycle. One that moves it from 1 to 0 gives a one-cycle stop pulse. A write that leaves bit 0 unchanged gives no pulse.
- R8: A byte write to slice offset 4+k replaces byte k of the descriptor base. A word write at offset 4 replaces the whole value. Bits 1:0 are always stored as zero. Byte and word reads return the stored value, and the base is presented on desc_base.
- R9: In the descriptor area, a half-word access, or a word access not at slice offset 4, is ignored as a write and reads as ones across its width.
- R10: Each channel has its own fully writable timing byte, and a write to one channel's copy leaves the other unchanged.
- R11: rd_valid is high exactly one cycle after a read strobe, with byte data in bits 7:0 and zeros above. After reset, every register held in the block is zero and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset in the window |
| acc_size | input | 2 | Access size code |
| acc_wdata | input | 32 | Write data, byte writes in bits 7:0 |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| mode_rd | input | 8 | Current shared mode register |
| mode_we | output | 1 | Mode register write / interrupt resync request |
| mode_wr_data | output | 8 | New mode register value |
| eng_active | input | CHANNELS | Engine activity level per channel |
| eng_err_set | input | CHANNELS | Engine error set pulse per channel |
| eng_irq_set | input | CHANNELS | Engine interrupt set pulse per channel |
| dma_start | output | CHANNELS | Start pulse per channel |
| dma_stop | output | CHANNELS | Stop pulse per channel |
| dma_dir | output | CHANNELS | Direction level per channel |
| desc_base | output | CHANNELS x 32 | Descriptor table base per channel |

## Verification
The hardest state to reach from the ports is an engine set pulse that lands in the very cycle a host write to the status byte tries to clear the same flag. Only in that collision does the set-over-clear priority matter. The stimulus task drives the engine pulse lines and the access strobe from one call, so a directed step can line the two up exactly. A long random phase then mixes engine pulses with random status writes, to catch collisions on both flags and on both channels.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } bm_size_e;

  localparam logic [7:0] CMD_KEEP  = 8'h09;
  localparam logic [7:0] MODE_BLK  = 8'h30;

  // mode register: only the block bits take the written value
  function automatic logic [7:0] mode_merge(input logic [7:0] cur, input logic [7:0] wd);
    return (cur & ~MODE_BLK) | (wd & MODE_BLK);
  endfunction

  // status: bit0 follows engine, bits 1/2 sticky with W1C (set wins), bits 6:5 r/w
  function automatic logic [7:0] status_next(input logic [7:0] cur, input logic we,
                                             input logic [7:0] wd, input logic act,
                                             input logic err_set, input logic irq_set);
    logic [7:0] n;
    n      = '0;
    n[0]   = act;
    n[1]   = err_set | (cur[1] & ~(we & wd[1]));
    n[2]   = irq_set | (cur[2] & ~(we & wd[2]));
    n[6:5] = we ? wd[6:5] : cur[6:5];
    return n;
  endfunction

  // descriptor base byte update, low two bits forced clear
  function automatic logic [31:0] desc_merge(input logic [31:0] cur, input logic [1:0] lane,
                                             input logic [7:0] b);
    logic [31:0] n;
    n = cur;
    n[{lane, 3'b000} +: 8] = b;
    n[1:0] = 2'b00;
    return n;
  endfunction

  // all-ones pattern over the access width for refused reads
  function automatic logic [31:0] fill_ones(input logic [1:0] sz);
    return (sz == SZ_HALF) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

endpackage

// File: rtl/ide_bm_decode.sv
module ide_bm_decode
  import ide_bm_pkg::*;
#(
  parameter int CHANNELS = 2,
  localparam int CH_W   = $clog2(CHANNELS),
  localparam int ADDR_W = CH_W + 3
) (
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  output logic [CH_W-1:0]   ch_sel,
  output logic [2:0]        off,
  output logic              byte_acc,
  output logic              desc_word,
  output logic              refused
);

  assign ch_sel    = acc_addr[ADDR_W-1:3];
  assign off       = acc_addr[2:0];
  assign byte_acc  = (acc_size == SZ_BYTE);
  assign desc_word = (acc_size == SZ_WORD) && (off == 3'd4);
  assign refused   = !byte_acc && !desc_word;

endmodule

// File: rtl/ide_bm_chan.sv
module ide_bm_chan
  import ide_bm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cmd,
  input  logic        wr_stat,
  input  logic        wr_tim,
  input  logic [3:0]  wr_desc_lane,
  input  logic        wr_desc_word,
  input  logic [31:0] wdata,
  input  logic        eng_act,
  input  logic        eng_err,
  input  logic        eng_irq,
  output logic [7:0]  cmd_q,
  output logic [7:0]  stat_q,
  output logic [7:0]  tim_q,
  output logic [31:0] desc_q,
  output logic        start_p,
  output logic        stop_p
);

  logic [31:0] desc_n;
  logic        go_rise;
  logic        go_fall;

  assign go_rise = wr_cmd &&  wdata[0] && !cmd_q[0];
  assign go_fall = wr_cmd && !wdata[0] &&  cmd_q[0];

  always_comb begin
    desc_n = desc_q;
    if (wr_desc_word) begin
      desc_n = {wdata[31:2], 2'b00};
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (wr_desc_lane[i]) desc_n = desc_merge(desc_n, 2'(i), wdata[7:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      stat_q  <= '0;
      tim_q   <= '0;
      desc_q  <= '0;
      start_p <= 1'b0;
      stop_p  <= 1'b0;
    end else begin
      if (wr_cmd) cmd_q <= wdata[7:0] & CMD_KEEP;
      if (wr_tim) tim_q <= wdata[7:0];
      stat_q  <= status_next(stat_q, wr_stat, wdata[7:0], eng_act, eng_err, eng_irq);
      desc_q  <= desc_n;
      start_p <= go_rise;
      stop_p  <= go_fall;
    end
  end

  AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_irq |=> stat_q[2]); // R5
  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err |=> stat_q[1]); // R5
  AST_IRQ_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[2] && !eng_irq) |=> !stat_q[2]); // R4
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_p && stop_p)); // R7
  AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !start_p); // R7
  AST_START_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |-> cmd_q[0]); // R7
  AST_DESC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    desc_q[1:0] == 2'b00); // R8

endmodule

// File: rtl/ide_bm_window.sv
module ide_bm_window
  import ide_bm_pkg::*;
#(
  parameter int CHANNELS = 2,
  localparam int CH_W   = $clog2(CHANNELS),
  localparam int ADDR_W = CH_W + 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  input  logic                       acc_write,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic [1:0]                 acc_size,
  input  logic [31:0]                acc_wdata,
  output logic                       rd_valid,
  output logic [31:0]                rd_data,
  input  logic [7:0]                 mode_rd,
  output logic                       mode_we,
  output logic [7:0]                 mode_wr_data,
  input  logic [CHANNELS-1:0]        eng_active,
  input  logic [CHANNELS-1:0]        eng_err_set,
  input  logic [CHANNELS-1:0]        eng_irq_set,
  output logic [CHANNELS-1:0]        dma_start,
  output logic [CHANNELS-1:0]        dma_stop,
  output logic [CHANNELS-1:0]        dma_dir,
  output logic [CHANNELS-1:0][31:0]  desc_base
);

  logic [CH_W-1:0] ch_sel;
  logic [2:0]      off;
  logic            byte_acc;
  logic            desc_word;
  logic            refused;
  logic            rd_req;
  logic            wr_req;
  logic            refused_wr;
  logic [31:0]     rd_next;

  logic [CHANNELS-1:0][7:0]  cmd_all;
  logic [CHANNELS-1:0][7:0]  stat_all;
  logic [CHANNELS-1:0][7:0]  tim_all;
  logic [CHANNELS-1:0][31:0] desc_all;

  ide_bm_decode #(.CHANNELS(CHANNELS)) u_dec (
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .ch_sel    (ch_sel),
    .off       (off),
    .byte_acc  (byte_acc),
    .desc_word (desc_word),
    .refused   (refused)
  );

  assign rd_req     = acc_valid && !acc_write;
  assign wr_req     = acc_valid &&  acc_write;
  assign refused_wr = wr_req && refused;

  // shared mode register port; mode_we doubles as the interrupt resync request
  assign mode_we      = wr_req && byte_acc && (off == 3'd1);
  assign mode_wr_data = mode_merge(mode_rd, acc_wdata[7:0]);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic       hit_b;
    logic [3:0] lane;
    assign hit_b = wr_req && byte_acc && (ch_sel == CH_W'(c));
    for (genvar k = 0; k < 4; k++) begin : g_lane
      assign lane[k] = hit_b && (off == 3'(4 + k));
    end

    ide_bm_chan u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_cmd       (hit_b && (off == 3'd0)),
      .wr_stat      (hit_b && (off == 3'd2)),
      .wr_tim       (hit_b && (off == 3'd3)),
      .wr_desc_lane (lane),
      .wr_desc_word (wr_req && desc_word && (ch_sel == CH_W'(c))),
      .wdata        (acc_wdata),
      .eng_act      (eng_active[c]),
      .eng_err      (eng_err_set[c]),
      .eng_irq      (eng_irq_set[c]),
      .cmd_q        (cmd_all[c]),
      .stat_q       (stat_all[c]),
      .tim_q        (tim_all[c]),
      .desc_q       (desc_all[c]),
      .start_p      (dma_start[c]),
      .stop_p       (dma_stop[c])
    );

    assign dma_dir[c]   = cmd_all[c][3];
    assign desc_base[c] = desc_all[c];
  end

  always_comb begin
    rd_next = '0;
    if (refused) begin
      rd_next = fill_ones(acc_size);
    end else if (desc_word) begin
      rd_next = desc_all[ch_sel];
    end else begin
      case (off)
        3'd0:    rd_next[7:0] = cmd_all[ch_sel];
        3'd1:    rd_next[7:0] = mode_rd;
        3'd2:    rd_next[7:0] = stat_all[ch_sel];
        3'd3:    rd_next[7:0] = tim_all[ch_sel];
        default: rd_next[7:0] = desc_all[ch_sel][{off[1:0], 3'b000} +: 8];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_next;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid); // R11
  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |-> (((mode_wr_data ^ mode_rd) & 8'hCF) == 8'h00)); // R3
  AST_REFUSED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    refused_wr |=> ($stable(cmd_all) && $stable(tim_all) && $stable(desc_all))); // R2 R9

endmodule

// File: tb/sim_ide_bm_window.sv
module sim_ide_bm_window;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [7:0]  mode_st;
  logic        mode_we;
  logic [7:0]  mode_wr_data;
  logic [1:0]  eng_active = '0;
  logic [1:0]  eng_err_set = '0;
  logic [1:0]  eng_irq_set = '0;
  logic [1:0]  dma_start, dma_stop, dma_dir;
  logic [1:0][31:0] desc_base;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ide_bm_window u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mode_rd(mode_st), .mode_we(mode_we),
    .mode_wr_data(mode_wr_data), .eng_active(eng_active), .eng_err_set(eng_err_set),
    .eng_irq_set(eng_irq_set), .dma_start(dma_start), .dma_stop(dma_stop),
    .dma_dir(dma_dir), .desc_base(desc_base)
  );

  // external mode register storage
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_st <= 8'h8C;
    else if (mode_we) mode_st <= mode_wr_data;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference model state
  byte unsigned m_cmd[2], m_st[2], m_tim[2];
  int unsigned  m_desc[2];
  bit           e_rdv;
  int unsigned  e_rd;
  string        e_tag;
  bit [1:0]     e_start, e_stop;

  always @(posedge clk) begin
    int ch, off;
    bit is_b, is_dw, wr;
    byte unsigned wd, clr;
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cmd[c] = 0; m_st[c] = 0; m_tim[c] = 0; m_desc[c] = 0;
      end
      e_rdv = 0; e_start = 0; e_stop = 0; e_rd = 0; e_tag = "R11";
    end else begin
      ch = acc_addr[3]; off = acc_addr[2:0];
      is_b = (acc_size == 0); is_dw = (acc_size == 2) && (off == 4);
      wr = acc_valid && acc_write; wd = acc_wdata[7:0];
      e_rdv = acc_valid && !acc_write; e_start = 0; e_stop = 0;
      if (e_rdv) begin
        if (is_b) begin
          case (off)
            0: begin e_rd = m_cmd[ch]; e_tag = "R6"; end
            1: begin e_rd = mode_st; e_tag = "R3"; end
            2: begin e_rd = m_st[ch]; e_tag = "R4"; end
            3: begin e_rd = m_tim[ch]; e_tag = "R10"; end
            default: begin e_rd = (m_desc[ch] >> (8 * (off - 4))) & 255; e_tag = "R8"; end
          endcase
        end else if (is_dw) begin
          e_rd = m_desc[ch]; e_tag = "R8";
        end else begin
          e_rd = (acc_size == 1) ? 32'h0000FFFF : 32'hFFFFFFFF;
          e_tag = (off < 4) ? "R2" : "R9";
        end
      end
      for (int c = 0; c < 2; c++) begin
        bit sw;
        sw = wr && is_b && (ch == c) && (off == 2);
        clr = sw ? wd : 8'h00;
        m_st[c][1] = eng_err_set[c] || (m_st[c][1] && !clr[1]);
        m_st[c][2] = eng_irq_set[c] || (m_st[c][2] && !clr[2]);
        m_st[c][0] = eng_active[c];
        if (sw) begin m_st[c][5] = wd[5]; m_st[c][6] = wd[6]; end
      end
      if (wr && is_b) begin
        case (off)
          0: begin
            e_start[ch] = wd[0] && !m_cmd[ch][0];
            e_stop[ch]  = !wd[0] && m_cmd[ch][0];
            m_cmd[ch] = {4'b0, wd[3], 2'b0, wd[0]};
          end
          3: m_tim[ch] = wd;
          4, 5, 6, 7: begin
            m_desc[ch][8 * (off - 4) +: 8] = wd;
            m_desc[ch] = m_desc[ch] & 32'hFFFFFFFC;
          end
          default: ;
        endcase
      end else if (wr && is_dw) begin
        m_desc[ch] = acc_wdata & 32'hFFFFFFFC;
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    bit ew;
    logic [7:0] emd;
    if (rst_n && !done) begin
      chk("R11", rd_valid, e_rdv);
      if (e_rdv) chk(e_tag, rd_data, e_rd);
      for (int c = 0; c < 2; c++) begin
        chk("R7", dma_start[c], e_start[c]);
        chk("R7", dma_stop[c], e_stop[c]);
        chk("R6", dma_dir[c], m_cmd[c][3]);
        chk("R8", desc_base[c], m_desc[c]);
      end
      ew = acc_valid && acc_write && (acc_size == 0) && (acc_addr[2:0] == 1);
      chk("R3", mode_we, ew);
      if (ew) begin
        emd = mode_st; emd[5:4] = acc_wdata[5:4];
        chk("R3", mode_wr_data, emd);
      end
    end
  end

  task automatic do_acc(input bit v, input bit w, input logic [3:0] a, input logic [1:0] sz,
                        input logic [31:0] d, input logic [1:0] es, input logic [1:0] is);
    @(posedge clk); #1;
    acc_valid = v; acc_write = w; acc_addr = a; acc_size = sz; acc_wdata = d;
    eng_err_set = es; eng_irq_set = is;
    @(posedge clk); #1;
    acc_valid = 0; acc_write = 0; eng_err_set = 0; eng_irq_set = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] sz, input string tag,
                    input logic [31:0] exp);
    do_acc(1, 0, a, sz, 0, 0, 0);
    chk(tag, rd_data, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    do_acc(1, 1, a, sz, d, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R11", desc_base[0], 0);
    chk("R11", {dma_start, dma_stop}, 0);
    rd(4'd2, 0, "R11", 0);
    rd(4'd9, 0, "R1", 8'h8C);
    wr(4'd0, 0, 32'hFF);
    rd(4'd0, 0, "R6", 8'h09);
    wr(4'd9, 0, 32'hFF);
    rd(4'd1, 0, "R3", 8'hBC);
    wr(4'd1, 0, 32'h00);
    rd(4'd9, 0, "R3", 8'h8C);
    wr(4'd3, 0, 32'hA5);
    wr(4'd11, 0, 32'h5A);
    rd(4'd3, 0, "R10", 8'hA5);
    rd(4'd11, 0, "R1", 8'h5A);
    @(posedge clk); #1 eng_active = 2'b10;
    do_acc(0, 0, 0, 0, 0, 2'b10, 2'b10);
    rd(4'd10, 0, "R4", 8'h07);
    wr(4'd10, 0, 32'hFE);
    rd(4'd10, 0, "R4", 8'h61);
    do_acc(1, 1, 4'd10, 0, 32'h04, 2'b00, 2'b10);
    rd(4'd10, 0, "R5", 8'h05);
    do_acc(1, 1, 4'd10, 0, 32'h02, 2'b10, 2'b00);
    rd(4'd10, 0, "R5", 8'h07);
    wr(4'd4, 0, 32'h77);
    wr(4'd5, 0, 32'h66);
    wr(4'd6, 0, 32'h55);
    wr(4'd7, 0, 32'h44);
    rd(4'd4, 2, "R8", 32'h44556674);
    wr(4'd12, 2, 32'h12345677);
    rd(4'd12, 2, "R8", 32'h12345674);
    rd(4'd12, 0, "R8", 32'h74);
    rd(4'd0, 1, "R2", 32'h0000FFFF);
    rd(4'd2, 2, "R2", 32'hFFFFFFFF);
    rd(4'd1, 3, "R2", 32'hFFFFFFFF);
    wr(4'd3, 2, 32'h0);
    rd(4'd3, 0, "R2", 8'hA5);
    rd(4'd4, 1, "R9", 32'h0000FFFF);
    wr(4'd5, 2, 32'h0);
    rd(4'd4, 2, "R9", 32'h44556674);
    rd(4'd13, 2, "R9", 32'hFFFFFFFF);
    wr(4'd0, 0, 32'h08);
    chk("R6", dma_dir[0], 1'b1);
    for (int i = 0; i < 600; i++) begin
      logic [1:0] sz;
      sz = ($urandom_range(0, 7) < 6) ? 2'd0 : 2'($urandom_range(1, 3));
      if ($urandom_range(0, 3) == 0) eng_active = 2'($urandom);
      do_acc($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, 4'($urandom), sz,
             $urandom, 2'($urandom_range(0, 3) == 0 ? $urandom : 0),
             2'($urandom_range(0, 3) == 0 ? $urandom : 0));
    end
    repeat (2) @(posedge clk);
    #1 done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; bad++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule